// File: doc/BRIEF.md
# Cartridge ROM Prefetch Buffer

This block sits between a processor bus port and a slow 16-bit cartridge ROM port. While the processor spends cycles elsewhere (idle cycles, or accesses below the ROM window that are timed by other logic), it fetches consecutive halfwords from ROM on its own countdown. It holds up to eight of them in a small FIFO. Processor reads in the ROM window are then served from the FIFO, and a halfword that is already buffered costs one cycle instead of a full ROM wait.

A nonsequential ROM read discards the buffer and begins fetching again at the requested address. Accesses to the save-memory region, writes into the ROM window and writes to the wait-control register freeze the buffer. When the enable bit is clear, ROM reads bypass the FIFO and pay the plain ROM wait counts. A request is held by the processor until `ready` is high, and `ready` together with `rd_data` is valid in that same cycle. One clock is one processor cycle.

Top module: `rom_prefetch_buf`

## Requirements
- R1: After reset the buffer is frozen and empty, and `ready` is 1 while no request is present. Idle ticks do not fill the buffer before the first ROM read, so the first enabled ROM read, even one flagged sequential, takes `wait_n` cycles.
- R2: With `pf_en`=1, a nonsequential read at an address in [0x0800_0000, 0x0E00_0000) restarts the buffer in its first cycle. The restart empties the FIFO, unfreezes it, sets the fetch address to the request address with bit 0 cleared, and loads the countdown with `wait_n`. An empty-FIFO halfword read therefore completes after `wait_n` cycles.
- R3: While unfrozen and enabled, the countdown drops by one in every tick cycle and in every cycle of an enabled ROM read. When it expires with fewer than eight halfwords held, the halfword at the fetch address is pushed, the fetch address grows by 2, and the countdown reloads with `wait_s`.
- R4: When the countdown expires with eight halfwords held, the countdown still reloads with `wait_s`, but nothing is pushed and the fetch address is kept. Later reads therefore return consecutive halfwords with none skipped.
- R5: A halfword taken while the FIFO holds data costs one cycle. A halfword taken from an empty FIFO waits the remaining countdown. In the cycle the countdown expires, the fetched halfword is returned directly and the read completes in that cycle.
- R6: `req_size` uses 0 for byte, 1 for half and 2 for word. A word read takes two halfwords, the first in bits 15:0 and the second in bits 31:16. A byte read takes one halfword and returns its bits 15:8 when `req_addr[0]`=1, otherwise bits 7:0, zero-extended. A half read returns the halfword zero-extended.
- R7: Any access in [0x0E00_0000, 0x1000_0000), any write in the ROM window, and any cycle with `ctrl_wr`=1 (including one with `tick`=1) freeze the buffer. Such an access gets `ready` in its first cycle. While frozen the countdown does not move. The next enabled ROM read restarts the buffer as in R2, even when flagged sequential.
- R8: With `pf_en`=0, a ROM read is served straight from the ROM port at the request address. Its first halfword costs `wait_n` (nonsequential) or `wait_s` (sequential), and the second halfword of a word costs `wait_s`. FIFO contents have no effect on the result.
- R9: `wait_n` and `wait_s` must be at least 1. With both equal to 1, a nonsequential half read completes in 1 cycle and a following sequential word read completes in 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one processor cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present, held until `ready` |
| req_addr | input | AW | Request byte address |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_seq | input | 1 | 1 = sequential access, 0 = nonsequential |
| req_write | input | 1 | 1 = write access |
| tick | input | 1 | A processor cycle elapsed outside this block (idle or low-region access) |
| pf_en | input | 1 | Prefetch enable bit of the wait control |
| ctrl_wr | input | 1 | Wait-control register is being written this cycle |
| wait_n | input | WW | Nonsequential halfword ROM wait in cycles |
| wait_s | input | WW | Sequential halfword ROM wait in cycles |
| rom_addr | output | AW | ROM port halfword address |
| rom_data | input | 16 | ROM port read data for `rom_addr` |
| rd_data | output | 32 | Read data, valid with `ready` |
| ready | output | 1 | Request completes in this cycle |

## Verification
The two functions that can land in the same cycle are the background refill and the processor's take. An empty-FIFO take that waits exactly until the countdown expires makes the push and the pop coincide. A full FIFO that expires during a one-cycle take makes the push refusal and the pop coincide. Both are provoked by choosing the idle gaps and the wait counts, including the case with both waits at 1. Each read is judged by its cycle count and returned data against a transaction-level timing model in the bench. A wrong bypass shows up as an extra cycle, and a wrong full rule shows up as a skipped halfword in later data. A control write that falls in a tick cycle is also exercised and must still freeze the buffer.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;
endpackage

// File: rtl/pfb_fifo.sv
module pfb_fifo #(
   parameter int DEPTH = 8,
   parameter int DW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pfb_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [PW-1:0] rd_q, wr_q, rd_e, wr_e;
   logic [CW-1:0] cnt_q, cnt_e;
   logic [DEPTH-1:0][DW-1:0] slot_v;

   // a restart in this cycle makes the buffer look empty at once
   assign rd_e  = clr ? '0 : rd_q;
   assign wr_e  = clr ? '0 : wr_q;
   assign cnt_e = clr ? '0 : cnt_q;
   assign empty = (cnt_e == '0);
   assign full  = (cnt_e == CW'(DEPTH));
   assign head  = slot_v[rd_e];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           q <= '0;
         else if (push && (wr_e == PW'(g)))    q <= wdata;
      end
      assign slot_v[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         rd_q  <= rd_e + PW'(pop);
         wr_q  <= wr_e + PW'(push);
         cnt_q <= cnt_e + CW'(push) - CW'(pop);
      end
   end

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (!empty || push));
endmodule

// File: rtl/pfb_refill.sv
module pfb_refill #(
   parameter int AW = 32,
   parameter int WW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          restart,
   input  logic [AW-1:0] restart_addr,
   input  logic [WW-1:0] wait_n,
   input  logic [WW-1:0] wait_s,
   input  logic          freeze,
   input  logic          adv,
   input  logic          full,
   output logic          fill,
   output logic [AW-1:0] fetch_addr,
   output logic          stalled
);
   logic [WW-1:0] cnt_q, cnt_e;
   logic [AW-1:0] addr_q;
   logic          stall_q, stall_e, run, expire;

   assign stall_e    = restart ? 1'b0 : stall_q;
   assign cnt_e      = restart ? wait_n : cnt_q;
   assign fetch_addr = restart ? restart_addr : addr_q;
   assign stalled    = stall_q;

   assign run    = adv && en && !stall_e && !freeze;
   assign expire = run && (cnt_e == WW'(1));
   assign fill   = expire && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_q <= 1'b1;
         cnt_q   <= WW'(1);
         addr_q  <= '0;
      end else begin
         stall_q <= freeze ? 1'b1 : stall_e;
         if (run) cnt_q <= expire ? wait_s : cnt_e - WW'(1);
         else     cnt_q <= cnt_e;
         addr_q  <= fill ? fetch_addr + AW'(2) : fetch_addr;
      end
   end

   // R7
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && !restart) |=> (cnt_q == $past(cnt_q)));

   // R4
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !restart) |=> (addr_q == $past(addr_q)));
endmodule

// File: rtl/rom_prefetch_buf.sv
module rom_prefetch_buf
   import pfb_pkg::*;
#(
   parameter int            AW      = 32,
   parameter int            WW      = 8,
   parameter int            DEPTH   = 8,
   parameter logic [AW-1:0] ROM_LO  = AW'(32'h0800_0000),
   parameter logic [AW-1:0] ROM_HI  = AW'(32'h0E00_0000),
   parameter logic [AW-1:0] SAVE_HI = AW'(32'h1000_0000)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic [1:0]    req_size,
   input  logic          req_seq,
   input  logic          req_write,
   input  logic          tick,
   input  logic          pf_en,
   input  logic          ctrl_wr,
   input  logic [WW-1:0] wait_n,
   input  logic [WW-1:0] wait_s,
   output logic [AW-1:0] rom_addr,
   input  logic [15:0]   rom_data,
   output logic [31:0]   rd_data,
   output logic          ready
);
   localparam int HW = 16;

   if (ROM_LO >= ROM_HI || ROM_HI > SAVE_HI) begin : g_bad_window
      $error("rom_prefetch_buf: address windows out of order");
   end
   if (AW < 2 || WW < 1) begin : g_bad_width
      $error("rom_prefetch_buf: widths too small");
   end

   acc_size_e     sz;
   logic          in_rom, in_save, first, is_rd, pf_rd, dir_rd, freeze;
   logic          restart, adv, fill, stalled, empty, full, pf_hit, dir_hit;
   logic          take, last, busy_q, half_q;
   logic [AW-1:0] fetch_addr, base_addr;
   logic [HW-1:0] head, take_data, lo_q;
   logic [WW-1:0] dcnt_q, dcnt_e;

   assign sz        = acc_size_e'(req_size);
   assign in_rom    = (req_addr >= ROM_LO) && (req_addr < ROM_HI);
   assign in_save   = (req_addr >= ROM_HI) && (req_addr < SAVE_HI);
   assign base_addr = {req_addr[AW-1:1], 1'b0};

   assign first   = req_valid && !busy_q;
   assign is_rd   = req_valid && !req_write && in_rom;
   assign pf_rd   = is_rd && pf_en;
   assign dir_rd  = is_rd && !pf_en;
   assign freeze  = ctrl_wr || (req_valid && in_save) || (req_valid && req_write && in_rom);
   assign restart = first && pf_rd && (!req_seq || stalled);
   assign adv     = pf_rd ? 1'b1 : tick;

   pfb_refill #(.AW(AW), .WW(WW)) u_refill (
      .clk(clk), .rst_n(rst_n), .en(pf_en), .restart(restart),
      .restart_addr(base_addr), .wait_n(wait_n), .wait_s(wait_s),
      .freeze(freeze), .adv(adv), .full(full), .fill(fill),
      .fetch_addr(fetch_addr), .stalled(stalled)
   );

   pfb_fifo #(.DEPTH(DEPTH), .DW(HW)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(restart), .push(fill), .wdata(rom_data),
      .pop(pf_hit), .head(head), .empty(empty), .full(full)
   );

   // direct path when prefetch is off: plain ROM wait per halfword
   assign dcnt_e  = first ? (req_seq ? wait_s : wait_n) : dcnt_q;
   assign dir_hit = dir_rd && (dcnt_e == WW'(1));

   assign pf_hit    = pf_rd && (!empty || fill);
   assign take      = pf_hit || dir_hit;
   assign take_data = (pf_rd && !empty) ? head : rom_data;
   assign last      = (sz != SZ_WORD) || half_q;
   assign ready     = is_rd ? (take && last) : 1'b1;
   assign rom_addr  = dir_rd ? (base_addr + (half_q ? AW'(2) : AW'(0))) : fetch_addr;

   always_comb begin
      case (sz)
         SZ_BYTE: rd_data = {24'd0, req_addr[0] ? take_data[15:8] : take_data[7:0]};
         SZ_WORD: rd_data = {take_data, lo_q};
         default: rd_data = {16'd0, take_data};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         half_q <= 1'b0;
         lo_q   <= '0;
         dcnt_q <= WW'(1);
      end else begin
         busy_q <= req_valid && !ready;
         if (take) half_q <= !last;
         if (take && !last) lo_q <= take_data;
         if (dir_rd) dcnt_q <= dir_hit ? wait_s : dcnt_e - WW'(1);
      end
   end

   // R7
   freeze_sets_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> stalled);

   // R2
   restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !ctrl_wr) |=> !stalled);

   // R8
   direct_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_rd |-> !fill);

   // R9
   wait_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((wait_n != '0) && (wait_s != '0)));
endmodule

// File: tb/sim_rom_prefetch_buf.sv
module sim_rom_prefetch_buf;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_seq, req_write, tick, pf_en, ctrl_wr;
   logic [31:0] req_addr;
   logic [1:0]  req_size;
   logic [7:0]  wait_n, wait_s;
   logic [31:0] rom_addr;
   logic [15:0] rom_data;
   logic [31:0] rd_data;
   logic        ready;

   always #10 clk = ~clk;

   function automatic logic [15:0] romf(input logic [31:0] a);
      return 16'(a[16:1] * 16'd7) + 16'h1234;
   endfunction

   assign rom_data = romf(rom_addr);

   rom_prefetch_buf u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_seq(req_seq), .req_write(req_write), .tick(tick),
      .pf_en(pf_en), .ctrl_wr(ctrl_wr), .wait_n(wait_n), .wait_s(wait_s),
      .rom_addr(rom_addr), .rom_data(rom_data), .rd_data(rd_data), .ready(ready)
   );

   int n_run = 0, n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // transaction-level timing model
   int          m_en, m_stall, m_slots, m_wait, m_in, m_out;
   logic [31:0] m_addr;
   logic [31:0] m_q [8];

   task automatic m_step(input int n);
      if (m_en == 0 || m_stall != 0) return;
      m_wait -= n;
      while (m_wait <= 0) begin
         if (m_slots < 8) begin
            m_q[m_out] = m_addr;
            m_out = (m_out + 1) % 8;
            m_slots++;
            m_addr += 2;
         end
         m_wait += int'(wait_s);
      end
   endtask

   task automatic m_take(output logic [31:0] a, inout int cyc);
      if (m_slots > 0) begin
         cyc += 1;
         m_step(1);
      end else begin
         int w = m_wait;
         cyc += w;
         m_step(w);
      end
      a = m_q[m_in];
      m_in = (m_in + 1) % 8;
      m_slots--;
   endtask

   task automatic op_idle(input int n, input logic wr_ctl = 1'b0);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0; req_write = 1'b0; ctrl_wr = wr_ctl; tick = 1'b1;
      end
      if (wr_ctl) m_stall = 1; else m_step(n);
   endtask

   task automatic op_ctrl(input logic v);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; tick = 1'b0; ctrl_wr = 1'b1; pf_en = v;
      m_en = v; m_stall = 1;
   endtask

   task automatic op_acc(input string tag, input logic [31:0] a, input logic [1:0] sz,
                         input logic seq, input logic wr);
      int          ecyc, cyc;
      logic [31:0] a0, a1, edat;
      logic [15:0] h0, h1;
      logic        rom, chkd;
      rom  = (a >= 32'h0800_0000) && (a < 32'h0E00_0000);
      ecyc = 0; chkd = 1'b0;
      a1   = 32'h0;
      if (rom && !wr) begin
         chkd = 1'b1;
         if (m_en != 0) begin
            if (!seq || m_stall != 0) begin
               m_stall = 0; m_slots = 0; m_in = 0; m_out = 0;
               m_addr = {a[31:1], 1'b0}; m_wait = int'(wait_n);
            end
            m_take(a0, ecyc);
            if (sz == 2'd2) m_take(a1, ecyc);
         end else begin
            a0   = {a[31:1], 1'b0};
            a1   = a0 + 2;
            ecyc = seq ? int'(wait_s) : int'(wait_n);
            if (sz == 2'd2) ecyc += int'(wait_s);
         end
         h0 = romf(a0); h1 = romf(a1);
         case (sz)
            2'd0:    edat = {24'd0, a[0] ? h0[15:8] : h0[7:0]};
            2'd2:    edat = {h1, h0};
            default: edat = {16'd0, h0};
         endcase
      end else begin
         ecyc = 1;
         edat = 32'h0;
         if (a >= 32'h0800_0000 && a < 32'h1000_0000) m_stall = 1;
      end
      @(negedge clk);
      ctrl_wr = 1'b0; tick = 1'b0; req_valid = 1'b1;
      req_addr = a; req_size = sz; req_seq = seq; req_write = wr;
      cyc = 0;
      forever begin
         #2;
         cyc++;
         if (ready || cyc > 500) break;
         @(negedge clk);
      end
      chk({tag, " cycles"}, 32'(cyc), 32'(ecyc));
      if (chkd) chk({tag, " data"}, rd_data, edat);
   endtask

   localparam int NV = 27;
   localparam logic [1:0] K_IDLE = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_CTL = 2'd3;
   // {kind, addr, size, seq, count}
   localparam logic [44:0] VEC [NV] = '{
      {K_CTL,  32'h0,         2'd0, 1'b1, 8'd0},
      {K_RD,   32'h0800_0100, 2'd1, 1'b0, 8'd0},
      {K_RD,   32'h0800_0102, 2'd1, 1'b1, 8'd0},
      {K_IDLE, 32'h0,         2'd0, 1'b0, 8'd10},
      {K_RD,   32'h0800_0104, 2'd2, 1'b1, 8'd0},
      {K_RD,   32'h0800_0109, 2'd0, 1'b1, 8'd0},
      {K_IDLE, 32'h0,         2'd0, 1'b0, 8'd30},
      {K_RD,   32'h0800_010A, 2'd2, 1'b1, 8'd0},
      {K_RD,   32'h0800_010E, 2'd2, 1'b1, 8'd0},
      {K_RD,   32'h0800_0112, 2'd2, 1'b1, 8'd0},
      {K_RD,   32'h0800_0116, 2'd2, 1'b1, 8'd0},
      {K_WR,   32'h0800_0000, 2'd1, 1'b0, 8'd0},
      {K_IDLE, 32'h0,         2'd0, 1'b0, 8'd5},
      {K_RD,   32'h0800_0200, 2'd1, 1'b1, 8'd0},
      {K_IDLE, 32'h0,         2'd0, 1'b0, 8'd4},
      {K_RD,   32'h0E00_0010, 2'd0, 1'b0, 8'd0},
      {K_IDLE, 32'h0,         2'd0, 1'b0, 8'd3},
      {K_RD,   32'h0800_0300, 2'd2, 1'b1, 8'd0},
      {K_RD,   32'h0300_0000, 2'd2, 1'b0, 8'd0},
      {K_IDLE, 32'h0,         2'd0, 1'b0, 8'd2},
      {K_RD,   32'h0800_0304, 2'd1, 1'b1, 8'd0},
      {K_CTL,  32'h0,         2'd0, 1'b0, 8'd0},
      {K_RD,   32'h0800_0400, 2'd2, 1'b0, 8'd0},
      {K_RD,   32'h0800_0405, 2'd0, 1'b1, 8'd0},
      {K_CTL,  32'h0,         2'd0, 1'b1, 8'd0},
      {K_RD,   32'h0800_0501, 2'd0, 1'b0, 8'd0},
      {K_RD,   32'h0800_0502, 2'd2, 1'b1, 8'd0}
   };
   localparam string TAG [NV] = '{
      "R7", "R2", "R5", "R3", "R3", "R6", "R4", "R4", "R4", "R4",
      "R3", "R7", "R7", "R7", "R7", "R7", "R7", "R7", "R1", "R5",
      "R5", "R8", "R8", "R8", "R6", "R6", "R5"
   };

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = 2'd0;
      req_seq = 1'b0; req_write = 1'b0; tick = 1'b0; pf_en = 1'b1;
      ctrl_wr = 1'b0; wait_n = 8'd3; wait_s = 8'd2;
      m_en = 1; m_stall = 1; m_slots = 0; m_wait = 1; m_in = 0; m_out = 0; m_addr = '0;
      for (int i = 0; i < 8; i++) m_q[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R1 ready at reset", 32'(ready), 32'd1);

      // R1: idle ticks after reset must not fill; seq read restarts
      op_idle(20);
      op_acc("R1 first read", 32'h0800_0000, 2'd1, 1'b1, 1'b0);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][44:43])
            K_IDLE:  op_idle(int'(VEC[i][7:0]));
            K_CTL:   op_ctrl(VEC[i][8]);
            K_WR:    op_acc(TAG[i], VEC[i][42:11], VEC[i][10:9], 1'b0, 1'b1);
            default: op_acc(TAG[i], VEC[i][42:11], VEC[i][10:9], VEC[i][8], 1'b0);
         endcase
      end

      // R9: minimum waits, fill and take meet in one cycle
      @(negedge clk);
      req_valid = 1'b0; tick = 1'b0; ctrl_wr = 1'b0; wait_n = 8'd1; wait_s = 8'd1;
      op_acc("R9 min wait half", 32'h0800_0600, 2'd1, 1'b0, 1'b0);
      op_acc("R9 min wait word", 32'h0800_0602, 2'd2, 1'b1, 1'b0);

      // R5: empty take waits only the remaining countdown
      @(negedge clk);
      req_valid = 1'b0; tick = 1'b0; wait_n = 8'd5; wait_s = 8'd4;
      op_acc("R2 long restart", 32'h0800_0700, 2'd2, 1'b0, 1'b0);
      op_idle(2);
      op_acc("R5 partial wait", 32'h0800_0704, 2'd1, 1'b1, 1'b0);

      // R7: control write in a tick cycle still freezes
      op_idle(1, 1'b1);
      op_idle(6);
      op_acc("R7 ctrl in tick", 32'h0800_0706, 2'd1, 1'b1, 1'b0);

      @(negedge clk);
      req_valid = 1'b0;
      finish_run();
   end
endmodule